// File: doc/BRIEF.md
# PS/2 Host Command Transmitter

This block sends a single command byte from a host controller to a PS/2 keyboard. It performs the host-initiated request-to-send handshake. First it holds the clock line low for a fixed inhibit period. Then it pulls the data line low as the start bit and releases the clock. From that point it follows the clock that the keyboard generates. Each bit is changed only while the keyboard holds the clock low.

The frame is eight data bits sent least significant bit first, then an odd parity bit. On the next clock low after the parity bit the block releases the data line. It then waits for the keyboard to pull data low as its acknowledge, and for one more clock low after that. Only then does it report completion with a one-cycle done pulse. Both lines are driven through open-drain pull enables. Both line inputs pass through two-flop synchronisers before any edge is taken from them.

While the block is busy, a neighbouring receiver must be held off. The done pulse tells that receiver to clear its inactivity timer and any bit it has pending.

Top module: `ps2_cmd_tx`

## Requirements
- R1: After reset, and whenever the block is idle, both pull enables are 0 (lines released), busy is 0 and done is 0.
- R2: A start request while idle is taken at that clock edge. From the next cycle, busy is 1 and the clock pull enable is 1.
- R3: The clock pull enable alone is asserted for exactly INHIBIT_CYCLES cycles. Then both pull enables are 1 for one cycle. Then the clock is released while the data pull stays asserted, which forms the start bit.
- R4: The data pull enable changes only in the cycle after a falling edge of the synchronised keyboard clock. The bit set up in a low phase is therefore held through the following rising edge.
- R5: On the first eight keyboard clock falling edges, the block sets up the command byte, bit 0 first.
- R6: On the ninth falling edge, the block sets up the parity bit. The nine bits together contain an odd number of ones.
- R7: On the tenth falling edge, the block releases the data line, so the keyboard reads a stop bit of 1.
- R8: Done is not raised until the keyboard has pulled data low (acknowledge) and a clock falling edge has followed that acknowledge. Done lasts exactly one cycle.
- R9: Busy stays 1 from the accepted start until done. In the cycle that done is 1, busy is 0.
- R10: A start request while busy is ignored. The byte in flight is unchanged, and no further transfer begins after done.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request to send cmd_i |
| cmd_i | input | 8 | Command byte, sampled with an accepted start |
| kbd_clk_i | input | 1 | Keyboard clock line level |
| kbd_dat_i | input | 1 | Keyboard data line level |
| clk_pull_o | output | 1 | 1 pulls the clock line low |
| dat_pull_o | output | 1 | 1 pulls the data line low |
| busy_o | output | 1 | Transfer in progress; holds off the receiver |
| done_o | output | 1 | One-cycle completion pulse; clears receiver timer and pending bit |

## Verification
The assertions assume the keyboard clock low phase is many system cycles long. A bit change therefore always follows a falling edge that the synchroniser has already seen. They also assume the keyboard drives the clock only after the host has released it. The bench keyboard model honours both assumptions. It waits for the start bit before clocking. Its half periods are drawn at random between 8 and 15 system cycles. It pulls the acknowledge only after the tenth rising edge, and pulls the final clock low only after that.

// File: rtl/ps2tx_pkg.sv
package ps2tx_pkg;
  localparam int BYTE_W = 8;
  localparam int FRAME_BITS = BYTE_W + 1;

  typedef logic [BYTE_W-1:0] cmd_byte_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_INHIBIT,
    ST_START,
    ST_SHIFT,
    ST_ACK,
    ST_ACKCLK
  } tx_state_t;

  // Bit that makes the count of ones over byte plus bit odd.
  function automatic logic odd_parity(input cmd_byte_t b);
    return ~(^b);
  endfunction
endpackage

// File: rtl/ps2_line_sync.sv
module ps2_line_sync #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] line_i,
  output logic [W-1:0] level_o
);
  for (genvar g = 0; g < W; g++) begin : g_sync
    logic meta_q, stab_q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        meta_q <= 1'b1;
        stab_q <= 1'b1;
      end else begin
        meta_q <= line_i[g];
        stab_q <= meta_q;
      end
    end
    assign level_o[g] = stab_q;
  end
endmodule

// File: rtl/ps2_hold_timer.sv
module ps2_hold_timer #(
  parameter int N = 20000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic expired_o
);
  localparam int CW = (N > 2) ? $clog2(N) : 1;
  localparam logic [CW-1:0] LAST = CW'(N - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !run_i) cnt_q <= '0;
    else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
  end

  assign expired_o = run_i && (cnt_q == LAST);
endmodule

// File: rtl/ps2_tx_fsm.sv
module ps2_tx_fsm
  import ps2tx_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      start_i,
  input  cmd_byte_t cmd_i,
  input  logic      clk_lvl_i,
  input  logic      dat_lvl_i,
  input  logic      inhibit_done_i,
  output logic      timer_run_o,
  output logic      clk_pull_o,
  output logic      dat_pull_o,
  output logic      busy_o,
  output logic      done_o,
  output logic      clk_fall_o,
  output logic      ack_phase_o
);
  localparam int BCW = $clog2(FRAME_BITS + 1);
  localparam logic [BCW-1:0] LAST_BIT = BCW'(FRAME_BITS);

  tx_state_t             state_q;
  logic [FRAME_BITS-1:0] frame_q;
  logic [BCW-1:0]        bit_cnt_q;
  logic                  dat_low_q, done_q, clk_prev_q, dat_prev_q;
  logic                  clk_fall, dat_fall;

  assign clk_fall = clk_prev_q && !clk_lvl_i;
  assign dat_fall = dat_prev_q && !dat_lvl_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      frame_q    <= '0;
      bit_cnt_q  <= '0;
      dat_low_q  <= 1'b0;
      done_q     <= 1'b0;
      clk_prev_q <= 1'b1;
      dat_prev_q <= 1'b1;
    end else begin
      clk_prev_q <= clk_lvl_i;
      dat_prev_q <= dat_lvl_i;
      done_q     <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          frame_q   <= {odd_parity(cmd_i), cmd_i};
          bit_cnt_q <= '0;
          state_q   <= ST_INHIBIT;
        end
        ST_INHIBIT: if (inhibit_done_i) state_q <= ST_START;
        ST_START: begin
          dat_low_q <= 1'b1;
          state_q   <= ST_SHIFT;
        end
        ST_SHIFT: if (clk_fall) begin
          if (bit_cnt_q == LAST_BIT) begin
            dat_low_q <= 1'b0;
            state_q   <= ST_ACK;
          end else begin
            dat_low_q <= ~frame_q[0];
            frame_q   <= frame_q >> 1;
            bit_cnt_q <= bit_cnt_q + 1'b1;
          end
        end
        ST_ACK: if (dat_fall) state_q <= ST_ACKCLK;
        ST_ACKCLK: if (clk_fall) begin
          state_q <= ST_IDLE;
          done_q  <= 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign timer_run_o = (state_q == ST_INHIBIT);
  assign clk_pull_o  = (state_q == ST_INHIBIT) || (state_q == ST_START);
  assign dat_pull_o  = (state_q == ST_START) || ((state_q == ST_SHIFT) && dat_low_q);
  assign busy_o      = (state_q != ST_IDLE);
  assign done_o      = done_q;
  assign clk_fall_o  = clk_fall;
  assign ack_phase_o = (state_q == ST_ACKCLK);
endmodule

// File: rtl/ps2_cmd_tx.sv
module ps2_cmd_tx #(
  parameter int INHIBIT_CYCLES = 20000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic [7:0] cmd_i,
  input  logic       kbd_clk_i,
  input  logic       kbd_dat_i,
  output logic       clk_pull_o,
  output logic       dat_pull_o,
  output logic       busy_o,
  output logic       done_o
);
  logic [1:0] lvl_w;
  logic       timer_run_w, inhibit_done_w;
  logic       clk_fall_w, ack_phase_w;

  ps2_line_sync #(.W(2)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .line_i({kbd_dat_i, kbd_clk_i}),
    .level_o(lvl_w)
  );

  ps2_hold_timer #(.N(INHIBIT_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n),
    .run_i(timer_run_w),
    .expired_o(inhibit_done_w)
  );

  ps2_tx_fsm u_fsm (
    .clk(clk), .rst_n(rst_n),
    .start_i(start_i), .cmd_i(cmd_i),
    .clk_lvl_i(lvl_w[0]), .dat_lvl_i(lvl_w[1]),
    .inhibit_done_i(inhibit_done_w),
    .timer_run_o(timer_run_w),
    .clk_pull_o(clk_pull_o), .dat_pull_o(dat_pull_o),
    .busy_o(busy_o), .done_o(done_o),
    .clk_fall_o(clk_fall_w), .ack_phase_o(ack_phase_w)
  );
endmodule

// File: rtl/ps2_cmd_tx_chk.sv
module ps2_cmd_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic start_i,
  input logic clk_pull_o,
  input logic dat_pull_o,
  input logic busy_o,
  input logic done_o,
  input logic clk_fall,
  input logic ack_phase
);
  a_r1_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!clk_pull_o && !dat_pull_o));

  a_r2_start_inhibits: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> (busy_o && clk_pull_o));

  a_r3_start_bit_held: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(clk_pull_o) |-> dat_pull_o);

  a_r4_change_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(dat_pull_o) && !clk_pull_o && !$past(clk_pull_o)) |-> $past(clk_fall));

  a_r8_done_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(ack_phase));

  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  a_r9_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);
endmodule

bind ps2_cmd_tx ps2_cmd_tx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i),
  .clk_pull_o(clk_pull_o), .dat_pull_o(dat_pull_o),
  .busy_o(busy_o), .done_o(done_o),
  .clk_fall(clk_fall_w), .ack_phase(ack_phase_w)
);

// File: tb/tb_ps2_cmd_tx.sv
module tb_ps2_cmd_tx;
  localparam int INH = 40;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [7:0] cmd = '0;
  logic dev_clk = 1'b0, dev_dat = 1'b0;
  logic clk_pull, dat_pull, busy, done;
  logic line_clk, line_dat;

  int checks = 0, errors = 0, done_cnt = 0, cyc = 0;

  assign line_clk = ~(clk_pull | dev_clk);
  assign line_dat = ~(dat_pull | dev_dat);

  ps2_cmd_tx #(.INHIBIT_CYCLES(INH)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .cmd_i(cmd),
    .kbd_clk_i(line_clk), .kbd_dat_i(line_dat),
    .clk_pull_o(clk_pull), .dat_pull_o(dat_pull),
    .busy_o(busy), .done_o(done)
  );

  always #2.5 clk = ~clk;

  always @(negedge clk) if (done) done_cnt++;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic bit exp_parity(input logic [7:0] b);
    int ones = 0;
    for (int i = 0; i < 8; i++) if (b[i]) ones++;
    return (ones % 2 == 0);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wait_neg(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic transfer(input logic [7:0] c, input bit poke);
    int n, h, d0;
    logic [7:0] got;
    bit par, stp, held;
    h = 8 + int'($urandom % 8);
    d0 = done_cnt;
    @(negedge clk); start = 1'b1; cmd = c;
    @(negedge clk); start = 1'b0; cmd = ~c;
    chk(busy && clk_pull, "R2", "busy and clock pull after start", {busy, clk_pull}, 3);
    n = 1;
    forever begin
      @(negedge clk);
      if (clk_pull && !dat_pull) n++; else break;
    end
    chk(n == INH, "R3", "inhibit length", n, INH);
    chk(clk_pull && dat_pull, "R3", "both pulled one cycle", {clk_pull, dat_pull}, 3);
    @(negedge clk);
    chk(!clk_pull && dat_pull, "R3", "clock released, start bit held", {clk_pull, dat_pull}, 1);
    wait_neg(6);
    got = '0; par = 0; stp = 0;
    for (int k = 0; k < 10; k++) begin
      dev_clk = 1'b1;
      wait_neg(h);
      held = line_dat;
      if (k < 8) got[k] = line_dat;
      else if (k == 8) par = line_dat;
      else stp = line_dat;
      dev_clk = 1'b0;
      if (poke && k == 3) begin start = 1'b1; cmd = ~c; @(negedge clk); start = 1'b0; wait_neg(h - 1); end
      else wait_neg(h);
      if (k < 9) chk(line_dat == held, "R4", "data stable through high phase", line_dat, held);
      if (k == 4) chk(busy == 1'b1, "R9", "busy during frame", busy, 1);
    end
    chk(got == c, poke ? "R10" : "R5", "byte received", got, c);
    chk(par == exp_parity(c), "R6", "parity bit", par, exp_parity(c));
    chk(stp == 1'b1, "R7", "stop bit released", stp, 1);
    wait_neg(5 + int'($urandom % 20));
    chk(done_cnt == d0 && busy, "R8", "no done before acknowledge", done_cnt - d0, 0);
    dev_dat = 1'b1;
    wait_neg(10);
    chk(done_cnt == d0, "R8", "no done before final clock low", done_cnt - d0, 0);
    dev_clk = 1'b1;
    wait_neg(8);
    dev_clk = 1'b0; dev_dat = 1'b0;
    wait_neg(4);
    chk(done_cnt == d0 + 1, "R8", "exactly one done cycle", done_cnt - d0, 1);
    chk(!busy && !clk_pull && !dat_pull, "R9", "idle after done", {busy, clk_pull, dat_pull}, 0);
    if (poke) begin
      wait_neg(INH + 10);
      chk(!busy && !clk_pull, "R10", "no transfer from ignored start", {busy, clk_pull}, 0);
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    wait_neg(4);
    chk(!clk_pull && !dat_pull && !busy && !done, "R1", "reset state",
        {clk_pull, dat_pull, busy, done}, 0);
    rst_n = 1'b1;
    wait_neg(3);
    chk(!clk_pull && !dat_pull && !busy && !done, "R1", "idle after reset",
        {clk_pull, dat_pull, busy, done}, 0);
    transfer(8'hFE, 1'b0);
    transfer(8'h00, 1'b0);
    transfer(8'hFF, 1'b0);
    transfer(8'h01, 1'b1);
    transfer(8'h80, 1'b0);
    for (int t = 0; t < 16; t++) transfer(8'($urandom), (t % 4) == 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule